// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block captures insertion and removal events for up to 32 bus slots. It presents them to system software through a small register window. A 16-bit event status register and a 16-bit event enable register are reached one byte at a time. Status bytes are write-one-to-clear. Enable bytes take plain writes.

Two read-only 32-bit masks report the slot of the most recent event. The "inserted" mask is used for an insertion and the "removed" mask for a removal. Every new event wipes both masks before it sets its single bit, so software only ever sees the latest slot.

An eject register turns a software write into a one-cycle eject request carrying a slot index. A removability register reports which slots accept hotplug. The single event output feeds the system control interrupt logic.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After reset, the following all read zero: status, enable, the inserted mask and the removed mask. The removability register reads all ones except the bits set in the `NO_HOTPLUG_MASK` parameter.
- R2: Address map on `bus_addr`:
  - 0x00 is status bits 7:0 and 0x01 is status bits 15:8.
  - 0x02 is enable bits 7:0 and 0x03 is enable bits 15:8.
  - 0x08 is the inserted mask and 0x0C is the removed mask.
  - 0x10 is the eject register and 0x14 is the removability mask.
  - Byte registers read zero-extended. Every other offset, including 0x10, reads zero.
- R3: A write to a status byte offset clears each status bit of that byte where `bus_wdata[7:0]` holds a 1. The other status byte does not change.
- R4: A write to an enable byte offset replaces that byte with `bus_wdata[7:0]`. The other enable byte does not change.
- R5: A hot event (`hp_valid`=1, `hp_cold`=0) on slot N does three things, visible from the cycle after the clock edge that samples it:
  - it clears both masks;
  - it then sets bit N of the inserted mask (`hp_insert`=1) or of the removed mask (`hp_insert`=0);
  - it sets status bit 1.
- R6: An event with `hp_cold`=1 changes no register and no output.
- R7: `sci_evt` is high exactly when status bit 1 and enable bit 1 are both set. It follows the registers with no added cycle.
- R8: A write of a nonzero value to 0x10 produces `eject_req` high for exactly one cycle after the write edge. `eject_slot` then carries the index of the lowest set bit of the written value. A write of zero produces no request.
- R9: Writes to the inserted mask, the removed mask and the removability register are ignored.
- R10: When a hot event and a write clearing status bit 1 arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| hp_valid | input | 1 | Slot event strobe |
| hp_insert | input | 1 | 1 for insertion, 0 for removal |
| hp_cold | input | 1 | Event belongs to a device present at power-up |
| hp_slot | input | 5 | Slot index of the event |
| sci_evt | output | 1 | Event contribution to the system control interrupt |
| eject_req | output | 1 | One-cycle eject request |
| eject_slot | output | 5 | Slot index of the eject request |

## Verification
The in-RTL assertions check these on every cycle:
- at most one mask bit is set in total;
- a hot event always leaves exactly one bit set and status bit 1 high;
- status write-one-to-clear takes effect in the following cycle;
- an eject request always follows a nonzero eject write;
- cold events leave the masks alone;
- the removability mask never moves.

Some behaviour only the bench scenarios can show:
- that the set bit sits at the right slot and in the right mask;
- that the eject index is the lowest set bit;
- the byte isolation of enable writes;
- the read map with its zero offsets.

The bench shows these by sweeping every slot and every eject index.

// File: rtl/shp_pkg.sv
package shp_pkg;
    localparam int ADDR_W = 5;
    localparam int HP_BIT = 1;

    localparam logic [ADDR_W-1:0] A_STS_LO = 5'h00;
    localparam logic [ADDR_W-1:0] A_STS_HI = 5'h01;
    localparam logic [ADDR_W-1:0] A_EN_LO  = 5'h02;
    localparam logic [ADDR_W-1:0] A_EN_HI  = 5'h03;
    localparam logic [ADDR_W-1:0] A_UP     = 5'h08;
    localparam logic [ADDR_W-1:0] A_DOWN   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_EJECT  = 5'h10;
    localparam logic [ADDR_W-1:0] A_RMV    = 5'h14;

    typedef enum logic [1:0] {
        SEL_STS_LO = 2'd0,
        SEL_STS_HI = 2'd1,
        SEL_EN_LO  = 2'd2,
        SEL_EN_HI  = 2'd3
    } byte_sel_e;

    typedef struct packed {
        logic [15:0] sts;
        logic [15:0] en;
        logic        sci;
    } evt_state_t;
endpackage

// File: rtl/shp_evt_regs.sv
module shp_evt_regs
    import shp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  byte_sel_e   byte_sel,
    input  logic [7:0]  wbyte,
    input  logic        hp_set,
    output logic [15:0] sts_o,
    output logic [15:0] en_o,
    output logic        sci_o
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (byte_sel)
                SEL_STS_LO: st_d.sts[7:0]  = st_q.sts[7:0]  & ~wbyte;
                SEL_STS_HI: st_d.sts[15:8] = st_q.sts[15:8] & ~wbyte;
                SEL_EN_LO:  st_d.en[7:0]   = wbyte;
                SEL_EN_HI:  st_d.en[15:8]  = wbyte;
                default:    st_d = st_q;
            endcase
        end
        // a new event outranks a same-cycle clear
        if (hp_set) st_d.sts[HP_BIT] = 1'b1;
        st_d.sci = st_d.sts[HP_BIT] & st_d.en[HP_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign en_o  = st_q.en;
    assign sci_o = st_q.sci;

    // R3
    sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && byte_sel == SEL_STS_LO && !hp_set) |=> ((st_q.sts[7:0] & $past(wbyte)) == 8'h00));
    // R3
    sts_other_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && byte_sel == SEL_STS_LO) |=> $stable(st_q.sts[15:8]));
    // R10
    hp_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_set |=> st_q.sts[HP_BIT]);
endmodule

// File: rtl/shp_slot_masks.sv
module shp_slot_masks #(
    parameter int NSLOT = 32,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hp_fire,
    input  logic             hp_insert,
    input  logic [IDX_W-1:0] hp_slot,
    output logic [NSLOT-1:0] up_o,
    output logic [NSLOT-1:0] down_o
);
    typedef struct packed {
        logic [NSLOT-1:0] up;
        logic [NSLOT-1:0] down;
    } mask_state_t;

    mask_state_t ms_d, ms_q;

    always_comb begin
        ms_d = ms_q;
        if (hp_fire) begin
            ms_d.up   = '0;
            ms_d.down = '0;
            if (hp_insert) ms_d.up[hp_slot]   = 1'b1;
            else           ms_d.down[hp_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ms_q <= '0;
        else        ms_q <= ms_d;
    end

    assign up_o   = ms_q.up;
    assign down_o = ms_q.down;

    // R5
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ms_q.up, ms_q.down}));
    // R5
    event_sets_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_fire |=> ($countones({ms_q.up, ms_q.down}) == 1));
    // R5
    event_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_fire && hp_insert) |=> (ms_q.down == '0));
endmodule

// File: rtl/shp_eject.sv
module shp_eject #(
    parameter int NSLOT = 32,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NSLOT-1:0] wval,
    output logic             req_o,
    output logic [IDX_W-1:0] slot_o
);
    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] slot;
    } ej_state_t;

    ej_state_t ej_d, ej_q;
    logic [IDX_W-1:0] low_idx;

    // lowest set bit: scan downwards so the last hit is the lowest
    always_comb begin
        low_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (wval[i]) low_idx = IDX_W'(i);
        end
    end

    always_comb begin
        ej_d.req  = wr_en && (wval != '0);
        ej_d.slot = ej_d.req ? low_idx : ej_q.slot;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ej_q <= '0;
        else        ej_q <= ej_d;
    end

    assign req_o  = ej_q.req;
    assign slot_o = ej_q.slot;

    // R8
    eject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wval != '0) |=> req_o);
    // R8
    eject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wval != '0) |=> !req_o);
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import shp_pkg::*;
#(
    parameter int               NSLOT           = 32,
    parameter int               DATA_W          = 32,
    parameter logic [NSLOT-1:0] NO_HOTPLUG_MASK = '0,
    localparam int              IDX_W           = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hp_valid,
    input  logic              hp_insert,
    input  logic              hp_cold,
    input  logic [IDX_W-1:0]  hp_slot,
    output logic              sci_evt,
    output logic              eject_req,
    output logic [IDX_W-1:0]  eject_slot
);
    logic             evt_wr, ej_wr, hp_fire;
    logic [15:0]      sts_q, en_q;
    logic [NSLOT-1:0] up_q, down_q, rmv_q;

    assign evt_wr  = bus_wr && (bus_addr[ADDR_W-1:2] == '0);
    assign ej_wr   = bus_wr && (bus_addr == A_EJECT);
    assign hp_fire = hp_valid && !hp_cold;

    shp_evt_regs u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (evt_wr),
        .byte_sel (byte_sel_e'(bus_addr[1:0])),
        .wbyte    (bus_wdata[7:0]),
        .hp_set   (hp_fire),
        .sts_o    (sts_q),
        .en_o     (en_q),
        .sci_o    (sci_evt)
    );

    shp_slot_masks #(.NSLOT(NSLOT)) u_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_fire   (hp_fire),
        .hp_insert (hp_insert),
        .hp_slot   (hp_slot),
        .up_o      (up_q),
        .down_o    (down_q)
    );

    shp_eject #(.NSLOT(NSLOT)) u_eject (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ej_wr),
        .wval   (bus_wdata[NSLOT-1:0]),
        .req_o  (eject_req),
        .slot_o (eject_slot)
    );

    // removability: loaded at reset, never written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) rmv_q <= ~NO_HOTPLUG_MASK;
        else        rmv_q <= rmv_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STS_LO: bus_rdata = DATA_W'(sts_q[7:0]);
            A_STS_HI: bus_rdata = DATA_W'(sts_q[15:8]);
            A_EN_LO:  bus_rdata = DATA_W'(en_q[7:0]);
            A_EN_HI:  bus_rdata = DATA_W'(en_q[15:8]);
            A_UP:     bus_rdata = DATA_W'(up_q);
            A_DOWN:   bus_rdata = DATA_W'(down_q);
            A_RMV:    bus_rdata = DATA_W'(rmv_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R6
    cold_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_valid && hp_cold) |=> ($stable(up_q) && $stable(down_q)));
    // R9
    rmv_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rmv_q == ~NO_HOTPLUG_MASK));
    // R7
    sci_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_evt |-> (sts_q[HP_BIT] && en_q[HP_BIT]));
endmodule

// File: tb/slot_hp_ctrl_bench.sv
module slot_hp_ctrl_bench;
    localparam logic [31:0] NOHP = 32'h8000_0005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hp_valid = 1'b0, hp_insert = 1'b0, hp_cold = 1'b0;
    logic [4:0]  hp_slot = '0;
    logic        sci_evt, eject_req;
    logic [4:0]  eject_slot;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slot_hp_ctrl #(.NO_HOTPLUG_MASK(NOHP)) u_slot_hp_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hp_valid(hp_valid),
        .hp_insert(hp_insert), .hp_cold(hp_cold), .hp_slot(hp_slot),
        .sci_evt(sci_evt), .eject_req(eject_req), .eject_slot(eject_slot)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic evt(input logic ins, input logic cold, input logic [4:0] s);
        hp_valid = 1'b1; hp_insert = ins; hp_cold = cold; hp_slot = s;
        @(negedge clk);
        hp_valid = 1'b0; hp_cold = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(5'h00, v); chk("R1 sts lo", v, 0);
        rd(5'h01, v); chk("R1 sts hi", v, 0);
        rd(5'h02, v); chk("R1 en lo", v, 0);
        rd(5'h03, v); chk("R1 en hi", v, 0);
        rd(5'h08, v); chk("R1 up", v, 0);
        rd(5'h0C, v); chk("R1 down", v, 0);
        rd(5'h14, v); chk("R1 rmv", v, ~NOHP);
        chk("R1 sci", {31'd0, sci_evt}, 0);
        chk("R1 eject", {31'd0, eject_req}, 0);

        // R4 enable byte writes
        wr(5'h03, 32'h0000_00A5);
        wr(5'h02, 32'h0000_003C);
        rd(5'h03, v); chk("R4 en hi", v, 32'hA5);
        rd(5'h02, v); chk("R4 en lo", v, 32'h3C);
        wr(5'h03, 32'hFFFF_FF00);
        rd(5'h02, v); chk("R4 en lo kept", v, 32'h3C);
        rd(5'h03, v); chk("R4 en hi cleared", v, 32'h00);
        wr(5'h02, 32'h0);

        // R5 sweep every slot, insert then remove
        for (int s = 0; s < 32; s++) begin
            evt(1'b1, 1'b0, 5'(s));
            rd(5'h08, v); chk("R5 up after insert", v, 32'h1 << s);
            rd(5'h0C, v); chk("R5 down after insert", v, 0);
            evt(1'b0, 1'b0, 5'(s));
            rd(5'h0C, v); chk("R5 down after remove", v, 32'h1 << s);
            rd(5'h08, v); chk("R5 up after remove", v, 0);
        end
        rd(5'h00, v); chk("R5 sts bit1", v, 32'h02);
        chk("R7 sci masked", {31'd0, sci_evt}, 0);

        // R7 sci follows status and enable
        wr(5'h02, 32'h02);
        chk("R7 sci on", {31'd0, sci_evt}, 1);
        // R3 clears that miss bit 1 keep it
        wr(5'h01, 32'hFF);
        rd(5'h00, v); chk("R3 hi write keeps lo", v, 32'h02);
        wr(5'h00, 32'hFD);
        rd(5'h00, v); chk("R3 other bits clear", v, 32'h02);
        wr(5'h00, 32'h02);
        rd(5'h00, v); chk("R3 w1c bit1", v, 0);
        chk("R7 sci off", {31'd0, sci_evt}, 0);

        // R6 cold event changes nothing
        evt(1'b1, 1'b1, 5'd9);
        rd(5'h08, v); chk("R6 up", v, 0);
        rd(5'h0C, v); chk("R6 down", v, 32'h8000_0000);
        rd(5'h00, v); chk("R6 sts", v, 0);
        chk("R6 sci", {31'd0, sci_evt}, 0);

        // R10 same-cycle event and clear
        bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h02;
        hp_valid = 1'b1; hp_insert = 1'b1; hp_slot = 5'd4;
        @(negedge clk);
        bus_wr = 1'b0; hp_valid = 1'b0;
        rd(5'h00, v); chk("R10 set wins", v, 32'h02);
        chk("R10 sci", {31'd0, sci_evt}, 1);

        // R9 writes to masks and removability ignored
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'h1234_5678);
        wr(5'h14, 32'h0);
        rd(5'h08, v); chk("R9 up", v, 32'h10);
        rd(5'h0C, v); chk("R9 down", v, 0);
        rd(5'h14, v); chk("R9 rmv", v, ~NOHP);

        // R2 unused offsets read zero
        for (int a = 0; a < 32; a++) begin
            if (a != 0 && a != 1 && a != 2 && a != 3 && a != 8 && a != 12 && a != 20) begin
                rd(5'(a), v); chk("R2 unused offset", v, 0);
            end
        end

        // R8 eject sweep: value has bits s and above set
        for (int s = 0; s < 32; s++) begin
            wr(5'h10, ~((32'h1 << s) - 32'h1));
            chk("R8 eject pulse", {31'd0, eject_req}, 1);
            chk("R8 eject slot", {27'd0, eject_slot}, s);
            @(negedge clk);
            chk("R8 eject one cycle", {31'd0, eject_req}, 0);
        end
        wr(5'h10, 32'h0);
        chk("R8 zero no pulse", {31'd0, eject_req}, 0);

        finish_run();
    end
endmodule